// File: doc/BRIEF.md
# Saturating Cycle and Stall Counters

This block keeps two performance counters for a processor core. The cycle counter advances on every clock in which both the core-run enable and the counter enable are high. The stall counter advances on the subset of those clocks in which the core also reports that it could not fetch an instruction. Both counts can be read at any time through a small register read port.

The cycle counter never wraps. When it reaches the all-ones value it holds there and raises a request that tells the control register logic to drop the counter enable. Software restarts a measurement by writing the cycle counter while counting is stopped. That write zeroes the stall counter in the same clock, so the two counts always describe the same window. The stall counter cannot be written from the bus.

Top module: `perf_cnt_top`

## Requirements
- R1: On each clock in which `core_en_i` and `cnt_en_i` are both 1 and the cycle count is below all-ones, the cycle count rises by 1. The new value is visible after that clock edge.
- R2: On such a counting clock the stall count rises by 1 when `stall_i` is 1, and stays the same when `stall_i` is 0.
- R3: While either enable is 0, both counts hold their value, whatever `stall_i` does. Counting resumes from the held values when both enables return to 1.
- R4: The cycle count saturates at all-ones and does not wrap. Once it is saturated, further counting clocks change neither the cycle count nor the stall count.
- R5: `cnt_en_clr_o` is 1 in the clock after each counting clock that leaves the cycle count at all-ones, and 0 otherwise. Reset clears it to 0.
- R6: A write with `wr_sel_i` = 0 (the cycle counter) made while counting is stopped loads `wr_data_i` into the cycle count and zeroes the stall count on the same edge.
- R7: A write with `wr_sel_i` = 0 made while both enables are 1 is ignored, and the cycle count advances as in R1.
- R8: A write with `wr_sel_i` = 1 (the stall counter) has no effect. The stall count never exceeds the cycle count.
- R9: Reset sets both counts to 0. `rd_data_o` shows the cycle count when `rd_sel_i` = 0 and the stall count when `rd_sel_i` = 1, combinationally and at any time.
- R10: A stall on the clock that brings the cycle count to all-ones is still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_en_i | input | 1 | Core is enabled to run |
| cnt_en_i | input | 1 | Counter enable bit from the control register |
| stall_i | input | 1 | Core failed to fetch an instruction this clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = cycle counter, 1 = stall counter |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read target: 0 = cycle counter, 1 = stall counter |
| rd_data_o | output | 32 | Read data |
| cycle_o | output | 32 | Current cycle count |
| stall_o | output | 32 | Current stall count |
| cnt_en_clr_o | output | 1 | Request to clear the counter enable bit |

## Verification
The saturation corner, with the enable-clear request and the stall counted on the final clock, lies billions of clocks away from reset. The bench stops counting and uses the allowed write to preload the cycle counter two steps below all-ones. It then counts with stall held high, so that the last increment, the held saturated value and the request pulse all appear within a few clocks. The bench imitates the control register by dropping the counter enable after it sees the request.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
    // Register selector shared by the read and write paths
    typedef enum logic {
        SEL_CYCLE = 1'b0,
        SEL_STALL = 1'b1
    } cnt_sel_e;
endpackage

// File: rtl/perf_sat_inc.sv
module perf_sat_inc #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    output logic [WIDTH-1:0] plus1_o,
    output logic             at_max_o,
    output logic             next_max_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    always_comb begin
        plus1_o    = val_i + ONE;
        at_max_o   = (val_i == ALL_ONES);
        next_max_o = (val_i == (ALL_ONES - ONE));
    end
endmodule

// File: rtl/perf_rd_mux.sv
module perf_rd_mux
    import perf_cnt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             sel_i,
    input  logic [WIDTH-1:0] cycle_i,
    input  logic [WIDTH-1:0] stall_i,
    output logic [WIDTH-1:0] data_o
);
    always_comb begin
        if (cnt_sel_e'(sel_i) == SEL_STALL) data_o = stall_i;
        else                                data_o = cycle_i;
    end
endmodule

// File: rtl/perf_cnt_top.sv
module perf_cnt_top
    import perf_cnt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_en_i,
    input  logic             cnt_en_i,
    input  logic             stall_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_sel_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic [WIDTH-1:0] cycle_o,
    output logic [WIDTH-1:0] stall_o,
    output logic             cnt_en_clr_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cycle;
        logic [WIDTH-1:0] stall;
        logic             clr;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    logic             counting;
    logic             cyc_wr;
    logic [WIDTH-1:0] cyc_plus1;
    logic             cyc_at_max;
    logic             cyc_next_max;

    perf_sat_inc #(.WIDTH(WIDTH)) u_cyc_inc (
        .val_i      (st_q.cycle),
        .plus1_o    (cyc_plus1),
        .at_max_o   (cyc_at_max),
        .next_max_o (cyc_next_max)
    );

    perf_rd_mux #(.WIDTH(WIDTH)) u_rd_mux (
        .sel_i   (rd_sel_i),
        .cycle_i (st_q.cycle),
        .stall_i (st_q.stall),
        .data_o  (rd_data_o)
    );

    always_comb begin
        counting = core_en_i && cnt_en_i;
        // Clearing is only allowed while counting is stopped
        cyc_wr   = wr_en_i && (cnt_sel_e'(wr_sel_i) == SEL_CYCLE) && !counting;
        st_d     = st_q;
        st_d.clr = counting && (cyc_at_max || cyc_next_max);
        if (counting && !cyc_at_max) begin
            st_d.cycle = cyc_plus1;
            // stall <= cycle < max here, so no overflow
            if (stall_i) st_d.stall = st_q.stall + ONE;
        end else if (cyc_wr) begin
            st_d.cycle = wr_data_i;
            st_d.stall = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cycle_o      = st_q.cycle;
    assign stall_o      = st_q.stall;
    assign cnt_en_clr_o = st_q.clr;

    a_r1_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en_i && cnt_en_i && cycle_o != ALL_ONES) |=> (cycle_o == $past(cycle_o) + ONE));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(core_en_i && cnt_en_i) && !(wr_en_i && !wr_sel_i)) |=> ($stable(cycle_o) && $stable(stall_o)));

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en_i && cnt_en_i && cycle_o == ALL_ONES) |=> (cycle_o == ALL_ONES && $stable(stall_o)));

    a_r5_clr_req: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en_i && cnt_en_i && cycle_o == ALL_ONES - ONE) |=> cnt_en_clr_o);

    a_r8_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o <= cycle_o);
endmodule

// File: tb/perf_cnt_top_bench.sv
module perf_cnt_top_bench;
    localparam int W = 32;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         core_en = 1'b0, cnt_en = 1'b0, stall = 1'b0;
    logic         wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data, cyc, stl;
    logic         clr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    perf_cnt_top #(.WIDTH(W)) u_perf_cnt_top (
        .clk(clk), .rst_n(rst_n), .core_en_i(core_en), .cnt_en_i(cnt_en),
        .stall_i(stall), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data), .cycle_o(cyc), .stall_o(stl),
        .cnt_en_clr_o(clr)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_read(string req, logic [W-1:0] ec, logic [W-1:0] es);
        rd_sel = 1'b0; #1; chk(req, rd_data, ec);
        rd_sel = 1'b1; #1; chk(req, rd_data, es);
        rd_sel = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 reset cycle", cyc, '0);
        chk("R9 reset stall", stl, '0);
        chk("R5 reset clr", {31'b0, clr}, '0);
        chk_read("R9 reset read", '0, '0);
    endtask

    task automatic t_count();
        logic pat [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
        core_en = 1; cnt_en = 1;
        for (int i = 0; i < 5; i++) begin
            stall = pat[i];
            step();
        end
        stall = 0;
        chk("R1 cycle count", cyc, 5);
        chk("R2 stall count", stl, 3);
        chk_read("R9 read counts", 5, 3);
    endtask

    task automatic t_hold();
        core_en = 0; stall = 1;
        repeat (3) step();
        chk("R3 hold core off", cyc, 5);
        chk("R3 hold stall core off", stl, 3);
        core_en = 1; cnt_en = 0;
        repeat (3) step();
        chk("R3 hold cnt off", cyc, 5);
        chk("R3 hold stall cnt off", stl, 3);
        cnt_en = 1; stall = 0;
        repeat (2) step();
        chk("R3 resume", cyc, 7);
        chk("R2 no stall when low", stl, 3);
    endtask

    task automatic t_write_ignored();
        wr_en = 1; wr_sel = 0; wr_data = 32'h123;
        step();
        wr_en = 0;
        chk("R7 write while counting", cyc, 8);
        core_en = 0; cnt_en = 0;
        wr_en = 1; wr_sel = 1; wr_data = 32'h0;
        step();
        wr_en = 0;
        chk("R8 stall write ignored", stl, 3);
        chk("R8 cycle untouched", cyc, 8);
    endtask

    task automatic t_clear();
        wr_en = 1; wr_sel = 0; wr_data = 32'd100;
        step();
        wr_en = 0;
        chk("R6 cycle loaded", cyc, 100);
        chk("R6 stall zeroed", stl, 0);
        cnt_en = 1;  // core still off
        wr_en = 1; wr_data = 32'd0;
        step();
        wr_en = 0;
        chk("R6 clear with core off", cyc, 0);
    endtask

    task automatic t_saturate();
        core_en = 0; cnt_en = 0;
        wr_en = 1; wr_sel = 0; wr_data = MAXV - 2;
        step();
        wr_en = 0;
        core_en = 1; cnt_en = 1; stall = 1;
        step();
        chk("R1 near max", cyc, MAXV - 1);
        chk("R5 no early clr", {31'b0, clr}, 0);
        step();
        chk("R4 reach max", cyc, MAXV);
        chk("R10 stall on final clock", stl, 2);
        chk("R5 clr pulse", {31'b0, clr}, 1);
        step();
        chk("R4 no wrap", cyc, MAXV);
        chk("R4 stall frozen", stl, 2);
        cnt_en = 0; stall = 0;
        step();
        chk("R5 clr released", {31'b0, clr}, 0);
        chk("R4 still max", cyc, MAXV);
        chk_read("R9 read saturated", MAXV, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_count();
        t_hold();
        t_write_ignored();
        t_clear();
        t_saturate();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule